// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by walking up to three levels of translation tables held in memory. A request carries the logical address, a supervisor flag, a 32-bit translation control word and two 64-bit root pointers, one for supervisor accesses and one for user accesses. The walker fetches descriptors one at a time through a simple 32-bit read port. It ends with a one-cycle `done` pulse and the physical address, or with a one-cycle `fault` pulse.

The control word sets how many top address bits are skipped and how wide each level's index is. Each table descriptor chooses whether the next level uses 4-byte or 8-byte descriptors. A page descriptor ends the walk at whatever level it is found. When translation is disabled, the logical address comes back unchanged one cycle after the request.

Top module: `xlat_walker`

## Requirements
- R1: With control bit 31 clear, an accepted request gives `done` in the next cycle with `phys_addr` equal to the logical address, and no memory read is made.
- R2: The supervisor root pointer is used only when control bit 25 is set and `req_super` is high. In every other case the user root pointer is used.
- R3: A root pointer keeps its table address in bits 31:0, with bits 1:0 ignored, and its descriptor type in bits 33:32. A root type of 0 or 1 gives `fault` in the next cycle without any memory read.
- R4: Control bits 19:16 give the count of skipped top bits. Bits 15:12, 11:8 and 7:4 give the index widths of levels A, B and C. A level's index is the address bits just below everything consumed before it, and a width of 0 gives index 0. The index is scaled by the descriptor size and added to the table base.
- R5: Descriptor type codes are held in bits 1:0: 0 is invalid, 1 is page, 2 is short table and 3 is long table. A short descriptor takes one read, and it supplies both the type and the address word.
- R6: A long descriptor takes two reads, at the entry address and at the entry address plus 4. The first word gives the type and the second word gives the address.
- R7: The next table's base is the address word with bits 3:0 cleared. The type of a table descriptor (2 or 3) sets the descriptor size used at the next level.
- R8: A page descriptor at any level ends the walk. The physical address is the address word with bits 7:0 cleared, plus (as an addition, not an OR) the logical address bits below all bits consumed through that level.
- R9: An invalid descriptor at any level gives `fault`, and the walk stops.
- R10: A table descriptor (type 2 or 3) met at level C gives `fault`.
- R11: `done` and `fault` are never high together and are single-cycle pulses. `mem_req` holds with a stable `mem_addr` until `mem_ack`, and only one read is outstanding at a time.
- R12: After reset, `done`, `fault` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a translation (taken while idle) |
| req_addr | input | 32 | Logical address |
| req_super | input | 1 | Access is in supervisor mode |
| ctrl_word | input | 32 | Translation control word |
| sup_root | input | 64 | Supervisor root pointer |
| usr_root | input | 64 | User root pointer |
| mem_req | output | 1 | Descriptor read request, held until acknowledged |
| mem_addr | output | 32 | Descriptor byte address |
| mem_ack | input | 1 | Read response valid (one cycle) |
| mem_rdata | input | 32 | Read response data |
| done | output | 1 | Translation complete pulse |
| phys_addr | output | 32 | Physical address, valid with `done` |
| fault | output | 1 | Translation failure pulse |

## Verification
The walker is driven with walks that end at each of the three levels. Each walk uses a shared set of tables, so a wrong level index or a wrong scale factor sends the walk to a different descriptor and produces a different address or a fault. One pattern changes every control field but reuses the same tables, which tells correct prefix-sum index extraction apart from fixed positions. The offset it adds carries into the page frame, which tells addition apart from OR. Supervisor and user requests are run with the selection bit both set and clear. Short and long descriptor chains are compared by their read counts and read addresses, and each fault cause is driven alone.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W       = 32;
  localparam int FLD_W      = 4;
  localparam int NUM_LVL    = 3;
  localparam int EN_BIT     = 31;
  localparam int SUPSEL_BIT = 25;
  localparam int SKIP_LSB   = 16;
  localparam int LVL0_LSB   = 12;
  localparam int ROOT_TYPE_LSB = 32;
  localparam int PAGE_CLR   = 8;
  localparam int BASE_CLR   = 4;

  localparam logic [1:0] DT_INVALID = 2'd0;
  localparam logic [1:0] DT_PAGE    = 2'd1;
  localparam logic [1:0] DT_SHORT   = 2'd2;
  localparam logic [1:0] DT_LONG    = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HEAD = 2'd1,
    ST_TAIL = 2'd2
  } walk_st_e;
endpackage

// File: rtl/xlat_index_calc.sv
module xlat_index_calc #(
  parameter int VW = 32,
  parameter int FW = 4,
  parameter int SW = 6
) (
  input  logic [VW-1:0] vaddr,
  input  logic [SW-1:0] skip,
  input  logic [FW-1:0] width,
  input  logic [VW-1:0] base,
  input  logic          long_fmt,
  input  logic          tail,
  output logic [VW-1:0] entry_addr
);
  localparam logic [SW-1:0] VW_S = SW'(VW);

  logic [VW-1:0] shl;
  logic [VW-1:0] idx;
  logic [VW-1:0] scaled;
  logic [SW-1:0] rsh;

  always_comb begin
    shl    = vaddr << skip;
    rsh    = VW_S - SW'(width);
    idx    = (width == '0) ? '0 : (shl >> rsh);
    scaled = long_fmt ? (idx << 3) : (idx << 2);
    entry_addr = base + scaled + (tail ? VW'(4) : '0);
  end
endmodule

// File: rtl/xlat_page_merge.sv
module xlat_page_merge #(
  parameter int VW  = 32,
  parameter int SW  = 6,
  parameter int CLR = 8
) (
  input  logic [VW-1:0] vaddr,
  input  logic [SW-1:0] used,
  input  logic [VW-1:0] page_word,
  output logic [VW-1:0] paddr
);
  localparam logic [SW-1:0] VW_S = SW'(VW);

  logic [VW-1:0] keep_mask;
  logic [VW-1:0] frame;

  always_comb begin
    keep_mask = (used >= VW_S) ? '0 : ({VW{1'b1}} >> used);
    frame     = {page_word[VW-1:CLR], {CLR{1'b0}}};
    paddr     = frame + (vaddr & keep_mask);
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int LVLS = NUM_LVL,
  parameter int FW   = FLD_W,
  parameter int VW   = VA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [31:0]   req_addr,
  input  logic          req_super,
  input  logic [31:0]   ctrl_word,
  input  logic [63:0]   sup_root,
  input  logic [63:0]   usr_root,
  output logic          mem_req,
  output logic [31:0]   mem_addr,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          done,
  output logic [31:0]   phys_addr,
  output logic          fault
);
  localparam int LW = (LVLS > 1) ? $clog2(LVLS) : 1;
  localparam int SW = $clog2(((1 << FW) - 1) * (LVLS + 1) + 1);
  localparam logic [LW-1:0] LAST_LVL = LW'(LVLS - 1);

  walk_st_e      st_q, st_n;
  logic [LW-1:0] lvl_q, lvl_n;
  logic [VW-1:0] laddr_q, laddr_n;
  logic [FW-1:0] skip_q, skip_n;
  logic [FW-1:0] wid_q [LVLS];
  logic [FW-1:0] wid_n [LVLS];
  logic [VW-1:0] base_q, base_n;
  logic          long_q, long_n;
  logic [1:0]    head_q, head_n;
  logic [VW-1:0] pa_q, pa_n;
  logic          done_q, done_n;
  logic          fault_q, fault_n;

  logic          accept;
  logic          use_sup;
  logic [63:0]   root_sel;
  logic [1:0]    root_type;
  logic          step;
  logic [1:0]    step_type;
  logic          cap_en;
  logic          walk_en;

  logic [SW-1:0] pre [LVLS+1];
  logic [SW-1:0] cur_pre;
  logic [FW-1:0] cur_w;
  logic [SW-1:0] cur_used;
  logic [VW-1:0] page_pa;

  // Prefix sums of consumed bits, one stage per level
  assign pre[0] = SW'(skip_q);
  generate
    for (genvar k = 0; k < LVLS; k++) begin : g_pre
      assign pre[k+1] = pre[k] + SW'(wid_q[k]);
    end
  endgenerate

  assign cur_pre  = pre[lvl_q];
  assign cur_w    = wid_q[lvl_q];
  assign cur_used = cur_pre + SW'(cur_w);

  xlat_index_calc #(.VW(VW), .FW(FW), .SW(SW)) u_idx (
    .vaddr      (laddr_q),
    .skip       (cur_pre),
    .width      (cur_w),
    .base       (base_q),
    .long_fmt   (long_q),
    .tail       (st_q == ST_TAIL),
    .entry_addr (mem_addr)
  );

  xlat_page_merge #(.VW(VW), .SW(SW), .CLR(PAGE_CLR)) u_pg (
    .vaddr     (laddr_q),
    .used      (cur_used),
    .page_word (mem_rdata),
    .paddr     (page_pa)
  );

  assign accept    = (st_q == ST_IDLE) && req_valid && !done_q && !fault_q;
  assign use_sup   = ctrl_word[SUPSEL_BIT] && req_super;
  assign root_sel  = use_sup ? sup_root : usr_root;
  assign root_type = root_sel[ROOT_TYPE_LSB +: 2];

  // Next-state logic
  always_comb begin
    st_n      = st_q;
    lvl_n     = lvl_q;
    laddr_n   = laddr_q;
    skip_n    = skip_q;
    wid_n     = wid_q;
    base_n    = base_q;
    long_n    = long_q;
    head_n    = head_q;
    pa_n      = pa_q;
    done_n    = 1'b0;
    fault_n   = 1'b0;
    step      = 1'b0;
    step_type = DT_INVALID;

    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          laddr_n = req_addr;
          skip_n  = ctrl_word[SKIP_LSB +: FW];
          for (int k = 0; k < LVLS; k++) begin
            wid_n[k] = ctrl_word[LVL0_LSB - k*FW +: FW];
          end
          if (!ctrl_word[EN_BIT]) begin
            done_n = 1'b1;
            pa_n   = req_addr;
          end else if (!root_type[1]) begin
            fault_n = 1'b1;
          end else begin
            base_n = {root_sel[VW-1:2], 2'b00};
            long_n = root_type[0];
            lvl_n  = '0;
            st_n   = ST_HEAD;
          end
        end
      end
      ST_HEAD: begin
        if (mem_ack) begin
          if (long_q) begin
            head_n = mem_rdata[1:0];
            st_n   = ST_TAIL;
          end else begin
            step      = 1'b1;
            step_type = mem_rdata[1:0];
          end
        end
      end
      ST_TAIL: begin
        if (mem_ack) begin
          step      = 1'b1;
          step_type = head_q;
        end
      end
      default: st_n = ST_IDLE;
    endcase

    if (step) begin
      st_n = ST_IDLE;
      case (step_type)
        DT_PAGE: begin
          done_n = 1'b1;
          pa_n   = page_pa;
        end
        DT_SHORT, DT_LONG: begin
          if (lvl_q == LAST_LVL) begin
            fault_n = 1'b1;
          end else begin
            base_n = {mem_rdata[VW-1:BASE_CLR], {BASE_CLR{1'b0}}};
            long_n = step_type[0];
            lvl_n  = lvl_q + 1'b1;
            st_n   = ST_HEAD;
          end
        end
        default: fault_n = 1'b1;
      endcase
    end
  end

  assign cap_en  = accept;
  assign walk_en = (st_q != ST_IDLE) && mem_ack;

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      lvl_q   <= '0;
      laddr_q <= '0;
      skip_q  <= '0;
      for (int k = 0; k < LVLS; k++) wid_q[k] <= '0;
      base_q  <= '0;
      long_q  <= 1'b0;
      head_q  <= DT_INVALID;
      pa_q    <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      done_q  <= done_n;
      fault_q <= fault_n;
      if (cap_en) begin
        laddr_q <= laddr_n;
        skip_q  <= skip_n;
        for (int k = 0; k < LVLS; k++) wid_q[k] <= wid_n[k];
      end
      if (cap_en || walk_en) begin
        lvl_q  <= lvl_n;
        base_q <= base_n;
        long_q <= long_n;
        head_q <= head_n;
        pa_q   <= pa_n;
      end
    end
  end

  assign mem_req   = (st_q != ST_IDLE);
  assign done      = done_q;
  assign fault     = fault_q;
  assign phys_addr = pa_q;

  // Checks next to the sequencer
  assert_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !ctrl_word[EN_BIT]) |=> (done && !mem_req && phys_addr == $past(req_addr)))
    else $error("pass-through mismatch");

  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault))
    else $error("done and fault together");

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> !(done || fault))
    else $error("completion longer than one cycle");

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)))
    else $error("read request dropped or moved before ack");

  assert_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> !mem_req)
    else $error("read outstanding at completion");
endmodule

// File: tb/xlat_walker_test.sv
module xlat_walker_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        req_super;
  logic [31:0] ctrl_word;
  logic [63:0] sup_root;
  logic [63:0] usr_root;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic        done;
  logic [31:0] phys_addr;
  logic        fault;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int rd_total = 0;
  logic [31:0] rd_log [256];
  logic [31:0] mem [256];

  always #5 clk = ~clk;

  xlat_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_super(req_super), .ctrl_word(ctrl_word), .sup_root(sup_root),
    .usr_root(usr_root), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done),
    .phys_addr(phys_addr), .fault(fault)
  );

  // Memory model: ack one cycle after a request is seen
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack   <= mem_req && !mem_ack;
      mem_rdata <= mem[mem_addr[9:2]];
    end
  end

  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      rd_log[rd_total[7:0]] = mem_addr;
      rd_total = rd_total + 1;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL R11 watchdog: actual cycles=%0d expected below 100000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Runs one request; returns outcome, address, cycles and reads
  task automatic walk(input logic [31:0] a, input logic sup, input logic [31:0] cw,
                      input logic [63:0] sr, input logic [63:0] ur,
                      output logic d, output logic f, output logic [31:0] pa,
                      output int ncyc, output int nrd, output int first_rd);
    int start;
    start = rd_total;
    first_rd = start;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_super = sup; ctrl_word = cw;
    sup_root = sr; usr_root = ur;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    ncyc = 1;
    while (!(done || fault) && ncyc < 100) begin
      @(negedge clk);
      ncyc = ncyc + 1;
    end
    d = done; f = fault; pa = phys_addr;
    @(negedge clk);
    chk("R11 pulse ends", {30'd0, done, fault}, 32'd0);
    nrd = rd_total - start;
  endtask

  localparam logic [31:0] CW_STD = 32'h8008_4440;
  localparam logic [63:0] UROOT  = {32'h0000_0002, 32'h0000_0100};
  localparam logic [63:0] SROOT  = {32'h0000_0002, 32'h0000_0180};

  task automatic t_reset();
    chk("R12 reset done", {31'd0, done}, 32'd0);
    chk("R12 reset fault", {31'd0, fault}, 32'd0);
    chk("R12 reset mem_req", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_passthru();
    logic d, f; logic [31:0] pa; int nc, nr, fr;
    walk(32'h1234_5678, 1'b1, 32'h0008_4440, SROOT, UROOT, d, f, pa, nc, nr, fr);
    chk("R1 done", {31'd0, d}, 32'd1);
    chk("R1 address", pa, 32'h1234_5678);
    chk("R1 latency", nc, 1);
    chk("R1 no read", nr, 0);
  endtask

  task automatic t_short3();
    logic d, f; logic [31:0] pa; int nc, nr, fr;
    walk(32'hAB12_3DEF, 1'b0, CW_STD, SROOT, UROOT, d, f, pa, nc, nr, fr);
    chk("R5 three level done", {31'd0, d}, 32'd1);
    chk("R8 level C page address", pa, 32'h5555_5DEF);
    chk("R5 one read per level", nr, 3);
    chk("R4 level A entry", rd_log[fr[7:0]], 32'h0000_0104);
    chk("R7 level B entry uses cleared base", rd_log[(fr+1) & 255], 32'h0000_0208);
    chk("R4 level C entry", rd_log[(fr+2) & 255], 32'h0000_030C);
  endtask

  task automatic t_early_a();
    logic d, f; logic [31:0] pa; int nc, nr, fr;
    walk(32'hAB24_5678, 1'b0, CW_STD, SROOT, UROOT, d, f, pa, nc, nr, fr);
    chk("R8 level A page", pa, 32'h7704_5678);
    chk("R8 level A single read", nr, 1);
  endtask

  task automatic t_rootsel();
    logic d, f; logic [31:0] pa; int nc, nr, fr;
    walk(32'hAB1A_BCDE, 1'b1, CW_STD | 32'h0200_0000, SROOT, UROOT, d, f, pa, nc, nr, fr);
    chk("R2 supervisor root used", pa, 32'h660A_BCDE);
    walk(32'hAB1A_BCDE, 1'b0, CW_STD | 32'h0200_0000, SROOT, UROOT, d, f, pa, nc, nr, fr);
    chk("R2 user access uses user root", pa, 32'h8880_BCDE);
    chk("R8 level B page reads", nr, 2);
    walk(32'hAB1A_BCDE, 1'b1, CW_STD, SROOT, UROOT, d, f, pa, nc, nr, fr);
    chk("R2 select bit clear uses user root", pa, 32'h8880_BCDE);
  endtask

  task automatic t_long();
    logic d, f; logic [31:0] pa; int nc, nr, fr;
    walk(32'hAB12_CAFE, 1'b0, CW_STD, SROOT, {32'h0000_0003, 32'h0000_0140}, d, f, pa, nc, nr, fr);
    chk("R6 long chain address", pa, 32'h4440_CAFE);
    chk("R6 two reads per level", nr, 4);
    chk("R6 head read", rd_log[fr[7:0]], 32'h0000_0148);
    chk("R6 tail read at +4", rd_log[(fr+1) & 255], 32'h0000_014C);
    chk("R7 long next level entry", rd_log[(fr+2) & 255], 32'h0000_0390);
  endtask

  task automatic t_widths();
    logic d, f; logic [31:0] pa; int nc, nr, fr;
    walk(32'h53AB_CDEF, 1'b0, 32'h8000_2330, SROOT, {32'h0000_0002, 32'h0000_0103}, d, f, pa, nc, nr, fr);
    chk("R4 programmed widths, ignored root bits", rd_log[fr[7:0]], 32'h0000_0104);
    chk("R8 offset added with carry", pa, 32'h5601_1DEF);
    chk("R4 three reads", nr, 3);
  endtask

  task automatic t_faults();
    logic d, f; logic [31:0] pa; int nc, nr, fr;
    walk(32'hAB11_1111, 1'b0, CW_STD, SROOT, {32'h0000_0001, 32'h0000_0100}, d, f, pa, nc, nr, fr);
    chk("R3 root type 1 fault", {30'd0, d, f}, 32'd1);
    chk("R3 no read", nr, 0);
    chk("R3 latency", nc, 1);
    walk(32'hAB11_1111, 1'b0, CW_STD, SROOT, {32'h0000_0000, 32'h0000_0100}, d, f, pa, nc, nr, fr);
    chk("R3 root type 0 fault", {30'd0, d, f}, 32'd1);
    walk(32'hAB30_0000, 1'b0, CW_STD, SROOT, UROOT, d, f, pa, nc, nr, fr);
    chk("R9 invalid descriptor fault", {30'd0, d, f}, 32'd1);
    chk("R9 walk stops", nr, 1);
    walk(32'hAB14_5000, 1'b0, CW_STD, SROOT, UROOT, d, f, pa, nc, nr, fr);
    chk("R10 table at level C fault", {30'd0, d, f}, 32'd1);
    chk("R10 reads", nr, 3);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem[32'h104 >> 2] = 32'h0000_020E;
    mem[32'h108 >> 2] = 32'h7700_0001;
    mem[32'h10C >> 2] = 32'h0000_0000;
    mem[32'h184 >> 2] = 32'h6600_0001;
    mem[32'h208 >> 2] = 32'h0000_0302;
    mem[32'h210 >> 2] = 32'h0000_0302;
    mem[32'h228 >> 2] = 32'h8880_0001;
    mem[32'h30C >> 2] = 32'h5555_50F1;
    mem[32'h314 >> 2] = 32'h0000_0002;
    mem[32'h148 >> 2] = 32'h0000_0003;
    mem[32'h14C >> 2] = 32'h0000_0380;
    mem[32'h390 >> 2] = 32'h0000_0001;
    mem[32'h394 >> 2] = 32'h4440_0000;

    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_super = 1'b0;
    ctrl_word = '0; sup_root = '0; usr_root = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_passthru();
    t_short3();
    t_early_a();
    t_rootsel();
    t_long();
    t_widths();
    t_faults();
    summary();
    $finish;
  end
endmodule